// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI controller from the module clock. The division runs in two stages. A prescaler picks one of four small odd-or-prime factors (2, 3, 5, 7) and a scaler picks one of sixteen mostly power-of-two factors. Both are chosen by codes taken from fixed bit positions of the transfer attribute word. The bit period of SCK, in module clocks, is the product of the two factors.

The frame engine holds `run_i` high for as long as bits should be clocked. When the generator is idle and sees `run_i` high, it latches the attribute word, the polarity and the phase, and starts a frame. It then produces one SCK period after another. When `run_i` is low at the last cycle of a bit period, it stops and SCK returns to its idle level.

The data path uses two one-cycle strobes:
- `sample_o` marks the SCK edge on which received data is captured.
- `shift_o` marks the edge on which transmit data moves.

Which of these falls on the leading edge and which on the trailing edge depends on the phase setting.

Top module: `spi_sck_gen`

## Requirements
- R1: The prescaler code in `cfg_i[17:16]` selects a factor: code 0 gives 2, code 1 gives 3, code 2 gives 5 and code 3 gives 7.
- R2: The scaler code in `cfg_i[3:0]` selects a factor. Codes 0 to 3 give 2, 4, 6 and 8. A code c from 3 to 15 gives 2^c, from 8 up to 32768.
- R3: While a frame is active, each SCK bit period lasts exactly prescaler × scaler module clocks.
- R4: Within a bit period, SCK spends the first half at the non-idle level (the inverse of the latched polarity) and the second half at the idle level. Each half lasts exactly half the ratio.
- R5: While no frame is active, `sck_o` equals `cpol_i`, and `sample_o` and `shift_o` stay low.
- R6: When the generator is idle and `run_i` is sampled high at a clock edge, the first bit period begins on that edge. From the next cycle on, SCK is at the non-idle level.
- R7: The frame continues while `run_i` is high at the last cycle of a bit period. When `run_i` is low at that cycle, the generator goes idle at the next edge. A drop of `run_i` earlier in a period never cuts that period short.
- R8: With phase 0, `sample_o` pulses in the first cycle of each bit period and `shift_o` pulses in the first cycle of its second half. With phase 1 the two strobes swap places. Each strobe pulses exactly once per bit period.
- R9: The codes, the polarity and the phase are latched only when a frame starts from idle. Changes to them while a frame is active do not affect that frame.
- R10: While reset is asserted, the generator is idle and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Attribute word; prescaler code in bits 17:16, scaler code in bits 3:0 |
| cpol_i | input | 1 | Clock polarity: the idle level of SCK |
| cpha_i | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| run_i | input | 1 | Frame request from the frame engine |
| sck_o | output | 1 | Serial clock |
| sample_o | output | 1 | One-cycle strobe at the capture edge |
| shift_o | output | 1 | One-cycle strobe at the launch edge |

## Verification
The assertions assume that the configuration inputs may change at any cycle. Only the values present at a frame start matter, and the assertions check that nothing latched moves while a frame runs. They also assume that `run_i` comes from a synchronous frame engine and may drop at any cycle, not only at bit boundaries. The stimulus changes every input one time unit after the falling edge. It drops `run_i` both at period ends and mid-period, and it rewrites the codes and polarity in the middle of frames. A behavioural model with its own factor tables predicts the outputs for every cycle.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int CFG_W   = 32,
  parameter int PRE_LSB = 16,
  parameter int SCL_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             run_i,
  output logic             sck_o,
  output logic             sample_o,
  output logic             shift_o
);
  localparam int MAX_RATIO = 7 * 32768;
  localparam int CW = $clog2(MAX_RATIO + 1);

  function automatic logic [CW-1:0] ratio_of(input logic [1:0] pc, input logic [3:0] sc);
    int pre, scl;
    case (pc)
      2'd0: pre = 2;
      2'd1: pre = 3;
      2'd2: pre = 5;
      default: pre = 7;
    endcase
    scl = (sc < 4'd3) ? 2 * (int'(sc) + 1) : (1 << sc);
    return CW'(pre * scl);
  endfunction

  logic          active_q, pol_q, pha_q;
  logic [CW-1:0] cnt_q, ratio_q, half_q;
  logic [CW-1:0] ratio_new;
  logic          last, lead, trail;

  assign ratio_new = ratio_of(cfg_i[PRE_LSB+1:PRE_LSB], cfg_i[SCL_LSB+3:SCL_LSB]);
  assign last  = cnt_q == ratio_q - 1'b1;
  assign lead  = active_q && cnt_q == '0;
  assign trail = active_q && cnt_q == half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ratio_q  <= '0;
      half_q   <= '0;
      pol_q    <= 1'b0;
      pha_q    <= 1'b0;
    end else if (!active_q) begin
      if (run_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        ratio_q  <= ratio_new;
        half_q   <= ratio_new >> 1;
        pol_q    <= cpol_i;
        pha_q    <= cpha_i;
      end
    end else if (last) begin
      cnt_q <= '0;
      if (!run_i) active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o    = active_q ? (pol_q ^ (cnt_q < half_q)) : cpol_i;
  assign sample_o = pha_q ? trail : lead;
  assign shift_o  = pha_q ? lead : trail;

  p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q < ratio_q);
  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && shift_o));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !sample_o && !shift_o);
  p_latched_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && $past(active_q) |-> $stable(ratio_q) && $stable(pol_q) && $stable(pha_q));
  p_start_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> cnt_q == '0 && sck_o == !pol_q);
  p_edge_has_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && $past(active_q) && sck_o != $past(sck_o) |-> sample_o || shift_o);
  p_stop_only_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(last) && !$past(run_i));
endmodule

// File: tb/tb_spi_sck_gen.sv
`timescale 1ns/1ps
module tb_spi_sck_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_i = '0;
  logic cpol_i = 1'b0, cpha_i = 1'b0, run_i = 1'b0;
  logic sck_o, sample_o, shift_o;
  int checks = 0, failures = 0;

  spi_sck_gen dut (.clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .run_i(run_i), .sck_o(sck_o), .sample_o(sample_o), .shift_o(shift_o));

  always #2 clk = ~clk;

  int pre_tab [4]  = '{2, 3, 5, 7};
  int scl_tab [16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                       4096, 8192, 16384, 32768};

  int m_act = 0, m_pos = 0, m_n = 4, m_pol = 0, m_pha = 0;

  always @(posedge clk) begin
    if (!rst_n) m_act = 0;
    else if (m_act == 0) begin
      if (run_i) begin
        m_act = 1; m_pos = 0;
        m_n = pre_tab[cfg_i[17:16]] * scl_tab[cfg_i[3:0]];
        m_pol = cpol_i; m_pha = cpha_i;
      end
    end else if (m_pos == m_n - 1) begin
      m_pos = 0;
      if (!run_i) m_act = 0;
    end else m_pos++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_sck, e_smp, e_sft;
    if (m_act != 0) begin
      e_sck = (m_pos < m_n / 2) ? !m_pol[0] : m_pol[0];
      e_smp = m_pha != 0 ? (m_pos == m_n / 2) : (m_pos == 0);
      e_sft = m_pha != 0 ? (m_pos == 0) : (m_pos == m_n / 2);
    end else begin
      e_sck = cpol_i; e_smp = 0; e_sft = 0;
    end
    chk(sck_o === e_sck, "R3 R4 R5 sck", sck_o, e_sck);
    chk(sample_o === e_smp && shift_o === e_sft, "R8 strobes",
        {sample_o, shift_o}, {e_smp, e_sft});
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic wait_idle();
    while (m_act != 0) @(negedge clk);
    #1;
  endtask

  task automatic meas(input int pc, input int sc, input int exp, input string req);
    int cnt = 0;
    cfg_i = '0; cfg_i[17:16] = 2'(pc); cfg_i[3:0] = 4'(sc);
    cpha_i = 0; run_i = 1;
    do @(negedge clk); while (!sample_o);
    do begin @(negedge clk); cnt++; end while (!sample_o);
    #1 run_i = 0;
    chk(cnt == exp, req, cnt, exp);
    wait_idle();
  endtask

  initial begin
    #(190000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) tick();
    chk(sck_o == 0 && !sample_o && !shift_o, "R10 reset idle", {sck_o, sample_o, shift_o}, 0);
    cpol_i = 1; tick();
    chk(sck_o == 1, "R5 idle follows polarity", sck_o, 1);
    run_i = 1; tick();
    chk(!sample_o && !shift_o, "R10 no strobes in reset", {sample_o, shift_o}, 0);
    run_i = 0; rst_n = 1; tick();
    chk(sck_o == 1, "R5 idle after reset", sck_o, 1);

    cfg_i = '0; cpha_i = 0; run_i = 1;
    @(negedge clk);
    chk(sck_o == 0 && sample_o, "R6 first edge next cycle", {sck_o, sample_o}, 2'b01);
    #1 run_i = 0; wait_idle();

    meas(0, 0, 4, "R1 pre code 0");
    meas(1, 0, 6, "R1 pre code 1");
    meas(2, 0, 10, "R1 pre code 2");
    meas(3, 0, 14, "R1 pre code 3");
    for (int s = 0; s < 14; s++) meas(0, s, 2 * scl_tab[s], "R2 scaler code");
    meas(3, 5, 224, "R3 product 7x32");

    cpol_i = 0; cfg_i = '0; cfg_i[17:16] = 2'd1; run_i = 1; cnt = 0;
    @(negedge clk);
    while (sck_o == 1) begin cnt++; @(negedge clk); end
    chk(cnt == 3, "R4 half period", cnt, 3);
    #1 run_i = 0; wait_idle();

    cpha_i = 1; cfg_i = '0; run_i = 1;
    @(negedge clk);
    chk(shift_o && !sample_o, "R8 phase 1 shift first", {sample_o, shift_o}, 2'b01);
    #1 run_i = 0; wait_idle();

    cpha_i = 0; cfg_i = '0; cfg_i[3:0] = 4'd1; run_i = 1; tick(); tick();
    run_i = 0; cnt = 0;
    repeat (20) begin @(negedge clk); if (sample_o || shift_o) cnt++; end
    #1 chk(cnt == 1, "R7 period completes after early drop", cnt, 1);
    chk(sck_o == cpol_i, "R7 idle after stop", sck_o, cpol_i);

    cfg_i = '0; run_i = 1; tick();
    cfg_i[17:16] = 2'd3; cfg_i[3:0] = 4'd3; cpol_i = 1; cpha_i = 1;
    cnt = 0;
    do @(negedge clk); while (!sample_o);
    do begin @(negedge clk); cnt++; end while (!sample_o);
    chk(cnt == 4, "R9 ratio held mid-frame", cnt, 4);
    #1 run_i = 0; wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule